// File: doc/BRIEF.md
# Presettable Up Counter with Terminal-Count Reload

This block is a synchronous binary up counter, eight bits wide by default, that software-free hardware uses either as a free-running counter or as a programmable frequency divider. A parallel preset value can be loaded at any time. An active-low terminal-count flag marks the cycle in which the counter sits at its all-ones value while it is allowed to advance.

A mode input selects what happens at terminal count. With the mode low (the state the input must be tied to when unused) the counter wraps from all-ones back to zero. With the mode high the counter takes the preset value again on the edge where terminal count is flagged. With preset P, the count then repeats every 2^WIDTH − P cycles, and a preset of all-ones divides by one.

Counting is gated by an active-low carry input. The terminal-count flag includes that carry, so the flag of one stage can drive the carry input of the next, and a chain of stages on one clock forms a wider synchronous counter.

Top module: `tc_reload_counter`

## Requirements
- R1: While `rst` is high on a rising edge, the count becomes zero and `termCntN` reads 1 afterwards.
- R2: When `loadEn` is high (and `rst` low), the next edge loads `presetVal`, whatever `carryInN` and `autoReload` are; loading takes priority over counting and over the terminal-count reload.
- R3: With `rst` and `loadEn` low and `carryInN` low, each edge adds one to the count unless R6 or R7 applies.
- R4: With `rst` and `loadEn` low and `carryInN` high, the count holds its value.
- R5: `termCntN` is 0 exactly when every count bit is 1 and `carryInN` is 0; otherwise it is 1. It follows its inputs within the same cycle.
- R6: With `autoReload` low, an edge at which `termCntN` is 0 takes the count from all-ones to zero.
- R7: With `autoReload` high, an edge at which `termCntN` is 0 loads `presetVal`; with a constant preset P and `carryInN` held low the count returns to P every 2^WIDTH − P edges, and for P equal to all-ones the count stays at all-ones with `termCntN` held at 0.
- R8: Two stages on one clock, with the upper stage's `carryInN` driven by the lower stage's `termCntN`, count together as one counter of twice the width, and the upper `termCntN` is 0 only at the combined all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Parallel load request, active high |
| presetVal | input | WIDTH | Value taken on a load or a terminal-count reload |
| carryInN | input | 1 | Cascade carry / count enable, active low |
| autoReload | input | 1 | 1: reload preset at terminal count; 0: wrap (tie low if unused) |
| count | output | WIDTH | Current count |
| termCntN | output | 1 | Terminal count, active low |

## Verification
The bench builds one instance with the default WIDTH of 8, which keeps every reload period (up to 256 edges for a zero preset) short enough to measure edge by edge for presets 0, 100, 200, 254 and 255. It also builds two instances with WIDTH set to 4 and chains them through the carry, so the nibble carry at 0x?F and the combined wrap at 0xFF are both reached within a few dozen edges and compared against an 8-bit reference count.

// File: rtl/trc_pkg.sv
package trc_pkg;
  // Per-cycle action requested by the control for the count register.
  typedef struct packed {
    logic clear;   // force count to zero
    logic load;    // take the preset value (explicit load or reload)
    logic step;    // add one
  } cntStrobe_t;
endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loadEn,
  input  logic       autoReload,
  input  logic       carryInN,
  input  logic       allOnes,
  output cntStrobe_t strobe,
  output logic       termCntN
);
  logic carryActive;
  logic atTerm;
  logic reloadHit;

  assign carryActive = ~carryInN;
  assign atTerm      = allOnes & carryActive;
  assign reloadHit   = autoReload & atTerm;
  assign termCntN    = ~atTerm;

  always_comb begin
    strobe       = '0;
    strobe.clear = rst;
    if (!rst) begin
      if (loadEn || reloadHit) begin
        strobe.load = 1'b1;
      end else if (carryActive) begin
        strobe.step = 1'b1;
      end
    end
  end

  // R2: at most one action per cycle (load beats step)
  p_one_action_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

  // R4: carry inactive with no load never asks the datapath to move
  p_idle_no_step_r4: assert property (@(posedge clk) disable iff (rst)
    (carryInN && !loadEn) |-> (strobe == '0));
endmodule

// File: rtl/trc_datapath.sv
module trc_datapath
  import trc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  cntStrobe_t       strobe,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] value,
  output logic             allOnes
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] nextVal;

  always_comb begin
    nextVal = value;
    if (strobe.clear)     nextVal = ZERO;
    else if (strobe.load) nextVal = loadVal;
    else if (strobe.step) nextVal = value + ONE;
  end

  always_ff @(posedge clk) begin
    value <= nextVal;
  end

  assign allOnes = &value;
endmodule

// File: rtl/tc_reload_counter.sv
module tc_reload_counter
  import trc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] presetVal,
  input  logic             carryInN,
  input  logic             autoReload,
  output logic [WIDTH-1:0] count,
  output logic             termCntN
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  cntStrobe_t strobe;
  logic       allOnes;

  trc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .loadEn     (loadEn),
    .autoReload (autoReload),
    .carryInN   (carryInN),
    .allOnes    (allOnes),
    .strobe     (strobe),
    .termCntN   (termCntN)
  );

  trc_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .loadVal (presetVal),
    .value   (count),
    .allOnes (allOnes)
  );

  // R2: a load request lands the preset on the next edge
  p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (count == $past(presetVal)));

  // R3: enabled, not at terminal count: plus one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !carryInN && termCntN) |=> (count == $past(count) + ONE));

  // R4: carry inactive holds the count
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && carryInN) |=> $stable(count));

  // R6: free-run mode wraps to zero at terminal count
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !termCntN && !autoReload) |=> (count == '0));

  // R7: reload mode takes the preset at terminal count
  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !termCntN && autoReload) |=> (count == $past(presetVal)));
endmodule

// File: tb/test_tc_reload_counter.sv
module test_tc_reload_counter;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int HW    = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         loadEn = 1'b0;
  logic [W-1:0] presetVal = '0;
  logic         carryInN = 1'b1;
  logic         autoReload = 1'b0;
  logic         tieLow = 1'b0;
  logic [W-1:0] count;
  logic         termCntN;

  logic [HW-1:0] loCnt, hiCnt;
  logic          loTcN, hiTcN;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  tc_reload_counter #(.WIDTH(W)) i_tc_reload_counter (
    .clk(clk), .rst(rst), .loadEn(loadEn), .presetVal(presetVal),
    .carryInN(carryInN), .autoReload(autoReload),
    .count(count), .termCntN(termCntN)
  );

  tc_reload_counter #(.WIDTH(HW)) i_lo (
    .clk(clk), .rst(rst), .loadEn(loadEn), .presetVal(presetVal[HW-1:0]),
    .carryInN(carryInN), .autoReload(tieLow),
    .count(loCnt), .termCntN(loTcN)
  );

  tc_reload_counter #(.WIDTH(HW)) i_hi (
    .clk(clk), .rst(rst), .loadEn(loadEn), .presetVal(presetVal[W-1:HW]),
    .carryInN(loTcN), .autoReload(tieLow),
    .count(hiCnt), .termCntN(hiTcN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic loadValue(input logic [W-1:0] v);
    presetVal = v;
    loadEn    = 1'b1;
    tick();
    loadEn    = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; carryInN = 1'b0; autoReload = 1'b1;
    tick(); tick();
    check(count == 0, "R1 count", count, 0);
    check(termCntN == 1'b1, "R1 termCntN", termCntN, 1);
    rst = 1'b0; carryInN = 1'b1; autoReload = 1'b0;
  endtask

  task automatic t_load_priority();
    carryInN = 1'b0; autoReload = 1'b1;
    loadValue(8'h5A);
    check(count == 8'h5A, "R2 load while counting", count, 8'h5A);
    carryInN = 1'b1;
    loadValue(8'h33);
    check(count == 8'h33, "R2 load with carry idle", count, 8'h33);
    // load at terminal count with a different preset than the reload target
    carryInN = 1'b0;
    loadValue(8'hFF);
    presetVal = 8'h21; loadEn = 1'b1; autoReload = 1'b0;
    tick();
    loadEn = 1'b0;
    check(count == 8'h21, "R2 load beats wrap", count, 8'h21);
    carryInN = 1'b1;
    loadValue(8'h33);
  endtask

  task automatic t_count_hold();
    carryInN = 1'b0; autoReload = 1'b1; presetVal = 8'h77;
    for (int i = 1; i <= 5; i++) begin
      tick();
      check(count == 8'h33 + i, "R3 increment", count, 8'h33 + i);
    end
    carryInN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(count == 8'h38, "R4 hold", count, 8'h38);
    end
  endtask

  task automatic t_tc_flag();
    carryInN = 1'b1;
    loadValue(8'hFF);
    check(termCntN == 1'b1, "R5 all-ones carry idle", termCntN, 1);
    carryInN = 1'b0; #1;
    check(termCntN == 1'b0, "R5 all-ones carry active", termCntN, 0);
    carryInN = 1'b1; #1;
    loadValue(8'hFE);
    carryInN = 1'b0; #1;
    check(termCntN == 1'b1, "R5 not all-ones", termCntN, 1);
    carryInN = 1'b1;
  endtask

  task automatic t_wrap();
    autoReload = 1'b0; presetVal = 8'h40;
    loadValue(8'hFF);
    carryInN = 1'b0; presetVal = 8'h40;
    tick();
    check(count == 0, "R6 wrap to zero", count, 0);
    check(termCntN == 1'b1, "R6 flag released", termCntN, 1);
    carryInN = 1'b1;
  endtask

  task automatic t_reload(input int p);
    int k;
    autoReload = 1'b1; carryInN = 1'b1;
    loadValue(W'(p));
    carryInN = 1'b0;
    k = 0;
    do begin
      tick();
      k++;
    end while (count != W'(p) && k < 400);
    check(k == 256 - p, "R7 reload period", k, 256 - p);
    if (p == 255) begin
      tick();
      check(count == 8'hFF && termCntN == 1'b0, "R7 divide-by-one",
            {termCntN, count}, 8'hFF);
    end
    carryInN = 1'b1;
  endtask

  task automatic t_cascade();
    logic [W-1:0] m;
    autoReload = 1'b0; carryInN = 1'b1;
    loadValue(8'hED);
    m = 8'hED;
    check({hiCnt, loCnt} == m, "R8 cascade load", {hiCnt, loCnt}, m);
    carryInN = 1'b0; #1;
    for (int i = 0; i < 40; i++) begin
      check(hiTcN == (m != 8'hFF), "R8 upper flag", hiTcN, (m != 8'hFF));
      tick();
      m = m + 1'b1;
      check({hiCnt, loCnt} == m, "R8 cascade count", {hiCnt, loCnt}, m);
    end
    carryInN = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_load_priority();
    t_count_hold();
    t_tc_flag();
    t_wrap();
    t_reload(0);
    t_reload(100);
    t_reload(200);
    t_reload(254);
    t_reload(255);
    t_cascade();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule